// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Masking

This block holds an alarm time made of four BCD fields: seconds, minutes, hours and day of month. It compares that time with a time-of-day value supplied on input ports from an external counter. It does not count time itself. On each one-second strobe it evaluates the compare. When the alarm is armed, a match produces a single-cycle interrupt pulse.

Bit 7 of every alarm field is a repeat mask. The combination of set masks widens the compare so that the alarm fires once a month, day, hour or minute, or on every second. Software programs the fields and an interrupt control byte over a small byte-wide register bus. Each alarm write is range-checked, and an illegal value is discarded.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset every stored byte is 0x00, every read returns 0x00 and `irq_out` is low.
- R2: The register slots are at address 0 (alarm seconds), 1 (alarm minutes), 2 (alarm hours), 3 (alarm day) and 4 (interrupt control). Each slot stores and returns its full byte, mask bit included. Other addresses ignore writes and read as 0x00. `bus_rdata` shows the addressed slot one clock edge after the address is presented.
- R3: A seconds or minutes write is stored only if bits[6:4]*10 + bits[3:0] is at most 59. Otherwise the slot keeps its previous value.
- R4: An hours write is stored only if bits[5:4]*10 + bits[3:0] is at most 23. Otherwise the slot keeps its previous value.
- R5: A day write is stored only if bit[4]*10 + bits[3:0] is nonzero. Otherwise the slot keeps its previous value.
- R6: With all four mask bits (bit 7) clear, the alarm matches only when all of these are equal: day [5:0], hours [5:0], minutes [6:0] and seconds [6:0].
- R7: With only the day mask set, the alarm matches when hours, minutes and seconds are equal, whatever the day.
- R8: With the day and hour masks set and the others clear, the alarm matches when minutes and seconds are equal.
- R9: With the day, hour and minute masks set and the seconds mask clear, the alarm matches when seconds are equal.
- R10: Any other mask combination matches on every tick.
- R11: `irq_out` is high for exactly the one cycle after a clock edge that sampled `tick` high while the alarm matched and control bit 7 was set. Without a tick, or with control bit 7 clear, it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe once per second |
| tod_sec | input | 7 | Current seconds, BCD |
| tod_min | input | 7 | Current minutes, BCD |
| tod_hour | input | 6 | Current hours, BCD |
| tod_day | input | 6 | Current day of month, BCD |
| bus_addr | input | ADDR_W (3) | Register slot address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Alarm interrupt pulse |

## Verification
A write lands on the clock edge that samples the strobe. A read value is registered, so it is due one edge after the address. The bench presents a read on the falling edge after the write and samples it on the next falling edge. The interrupt pulse is registered from the tick, so it is sampled half a cycle after the edge that sees the tick, and checked low again one cycle later. Every one of the 256 write values is swept into each alarm field, and all 16 mask combinations are crossed with a one-field mismatch in each field. Each expected result is computed arithmetically from the mask and field rules.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int SLOT_SEC   = 0;
  localparam int SLOT_MIN   = 1;
  localparam int SLOT_HOUR  = 2;
  localparam int SLOT_DAY   = 3;
  localparam int SLOT_CTRL  = 4;
  localparam int NUM_SLOTS  = 5;
  localparam int MASK_BIT   = 7;
  localparam int ENABLE_BIT = 7;

  typedef enum logic [2:0] {
    RATE_MONTH, RATE_DAY, RATE_HOUR, RATE_MIN, RATE_SEC
  } rate_e;

  typedef struct packed {
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } alarm_t;

  // decimal value of a tens digit and a units nibble
  function automatic int bcd_pair(input logic [2:0] tens, input logic [3:0] units);
    return int'(tens) * 10 + int'(units);
  endfunction

  // legality of a value written into a given slot
  function automatic logic write_legal(input int slot, input logic [7:0] v);
    case (slot)
      SLOT_SEC, SLOT_MIN: return bcd_pair(v[6:4], v[3:0]) <= 59;
      SLOT_HOUR:          return bcd_pair({1'b0, v[5:4]}, v[3:0]) <= 23;
      SLOT_DAY:           return bcd_pair({2'b00, v[4]}, v[3:0]) != 0;
      default:            return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/alarm_regbank.sv
module alarm_regbank
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output alarm_t            alarm,
  output logic              alarm_en
);
  logic [7:0] slots [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] hit;
  logic [NUM_SLOTS-1:0] legal;
  logic [7:0] rd_next;
  logic past_ok;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      hit[i]   = we && (addr == ADDR_W'(i));
      legal[i] = write_legal(i, wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) slots[i] <= 8'h00;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++)
        if (hit[i] && legal[i]) slots[i] <= wdata;
    end
  end

  always_comb begin
    rd_next = 8'h00;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (addr == ADDR_W'(i)) rd_next = slots[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= 8'h00;
      past_ok <= 1'b0;
    end else begin
      rdata   <= rd_next;
      past_ok <= 1'b1;
    end
  end

  assign alarm.sec  = slots[SLOT_SEC];
  assign alarm.min  = slots[SLOT_MIN];
  assign alarm.hour = slots[SLOT_HOUR];
  assign alarm.day  = slots[SLOT_DAY];
  assign alarm_en   = slots[SLOT_CTRL][ENABLE_BIT];

  // R3: illegal seconds write leaves the slot untouched
  p_reject_sec_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(hit[SLOT_SEC] && !legal[SLOT_SEC])) |-> $stable(slots[SLOT_SEC]));
  // R4: illegal hours write leaves the slot untouched
  p_reject_hour_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(hit[SLOT_HOUR] && !legal[SLOT_HOUR])) |-> $stable(slots[SLOT_HOUR]));
  // R5: illegal day write leaves the slot untouched
  p_reject_day_r5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(hit[SLOT_DAY] && !legal[SLOT_DAY])) |-> $stable(slots[SLOT_DAY]));
endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  alarm_t     alarm,
  input  logic [6:0] now_sec,
  input  logic [6:0] now_min,
  input  logic [5:0] now_hour,
  input  logic [5:0] now_day,
  output logic       match
);
  rate_e rate;
  logic sec_eq, min_eq, hour_eq, day_eq;
  logic unused_alarm_bits;

  assign unused_alarm_bits = ^{alarm.hour[6], alarm.day[6]};

  assign sec_eq  = alarm.sec[6:0]  == now_sec;
  assign min_eq  = alarm.min[6:0]  == now_min;
  assign hour_eq = alarm.hour[5:0] == now_hour;
  assign day_eq  = alarm.day[5:0]  == now_day;

  always_comb begin
    case ({alarm.day[MASK_BIT], alarm.hour[MASK_BIT], alarm.min[MASK_BIT], alarm.sec[MASK_BIT]})
      4'b0000: rate = RATE_MONTH;
      4'b1000: rate = RATE_DAY;
      4'b1100: rate = RATE_HOUR;
      4'b1110: rate = RATE_MIN;
      default: rate = RATE_SEC;
    endcase
  end

  always_comb begin
    case (rate)
      RATE_MONTH: match = day_eq && hour_eq && min_eq && sec_eq;
      RATE_DAY:   match = hour_eq && min_eq && sec_eq;
      RATE_HOUR:  match = min_eq && sec_eq;
      RATE_MIN:   match = sec_eq;
      default:    match = 1'b1;
    endcase
  end

  // R10: a seconds mismatch can only match in the every-second rate
  p_sec_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (!sec_eq && rate != RATE_SEC) |-> !match);
endmodule

// File: rtl/alarm_irq_pulse.sv
module alarm_irq_pulse (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic match,
  input  logic enable,
  output logic irq_q
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      irq_q   <= tick && match && enable;
      past_ok <= 1'b1;
    end
  end

  // R11: no pulse while the alarm enable is clear
  p_gated_r11: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(enable)) |-> !irq_q);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [6:0]        tod_sec,
  input  logic [6:0]        tod_min,
  input  logic [5:0]        tod_hour,
  input  logic [5:0]        tod_day,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata,
  output logic              irq_out
);
  alarm_t alarm;
  logic   alarm_en;
  logic   match;
  logic   past_ok;

  alarm_regbank #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .alarm(alarm), .alarm_en(alarm_en)
  );

  alarm_matcher u_match (
    .clk(clk), .rst(rst), .alarm(alarm),
    .now_sec(tod_sec), .now_min(tod_min), .now_hour(tod_hour), .now_day(tod_day),
    .match(match)
  );

  alarm_irq_pulse u_irq (
    .clk(clk), .rst(rst), .tick(tick), .match(match), .enable(alarm_en),
    .irq_q(irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R11: every pulse follows an edge that sampled the tick
  p_pulse_on_tick_r11: assert property (@(posedge clk) disable iff (rst)
    (past_ok && irq_out) |-> $past(tick));
endmodule

// File: tb/rtc_alarm_match_bench.sv
module rtc_alarm_match_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [6:0] tod_sec = '0;
  logic [6:0] tod_min = '0;
  logic [5:0] tod_hour = '0;
  logic [5:0] tod_day = '0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_out;

  int n_checks = 0;
  int n_err = 0;

  always #5ns clk = ~clk;

  rtc_alarm_match u_rtc_alarm_match (
    .clk(clk), .rst(rst), .tick(tick), .tod_sec(tod_sec), .tod_min(tod_min),
    .tod_hour(tod_hour), .tod_day(tod_day), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic bit legal(input int slot, input int v);
    int t, u;
    u = v & 15;
    case (slot)
      0, 1: begin t = (v >> 4) & 7; return (t * 10 + u) <= 59; end
      2:    begin t = (v >> 4) & 3; return (t * 10 + u) <= 23; end
      default: begin t = (v >> 4) & 1; return (t * 10 + u) != 0; end
    endcase
  endfunction

  function automatic string slot_req(input int slot);
    case (slot)
      0, 1: return "R3";
      2:    return "R4";
      default: return "R5";
    endcase
  endfunction

  // apply a tick with the given time, check pulse then its end
  task automatic fire(input string req, input logic [6:0] s, input logic [6:0] m,
                      input logic [5:0] h, input logic [5:0] dy, input bit exp);
    tod_sec = s; tod_min = m; tod_hour = h; tod_day = dy; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check(req, {7'b0, irq_out}, {7'b0, exp});
    @(negedge clk);
    check("R11", {7'b0, irq_out}, 8'h00);
  endtask

  initial begin
    #1ms;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] shadow [4];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", {7'b0, irq_out}, 8'h00);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1", d, 8'h00);
    end
    // R2 control byte, unmapped addresses
    wr(3'd4, 8'hA5); rd(3'd4, d); check("R2", d, 8'hA5);
    wr(3'd6, 8'hFF); rd(3'd6, d); check("R2", d, 8'h00);
    rd(3'd5, d); check("R2", d, 8'h00);
    rd(3'd7, d); check("R2", d, 8'h00);
    // R3/R4/R5 full sweep of write values, full byte readback (R2)
    for (int s = 0; s < 4; s++) begin
      shadow[s] = 8'h00;
      for (int v = 0; v < 256; v++) begin
        wr(3'(s), 8'(v));
        if (legal(s, v)) shadow[s] = 8'(v);
        rd(3'(s), d);
        check(slot_req(s), d, shadow[s]);
      end
    end
    // R6..R10 every mask combination against one-field mismatches
    wr(3'd4, 8'h80);
    for (int mk = 0; mk < 16; mk++) begin
      bit ms, mm, mh, md;
      int rate;
      string req;
      ms = mk[0]; mm = mk[1]; mh = mk[2]; md = mk[3];
      wr(3'd0, {ms, 7'h12});
      wr(3'd1, {mm, 7'h34});
      wr(3'd2, {mh, 7'h05});
      wr(3'd3, {md, 7'h17});
      if (!md && !mh && !mm && !ms) begin rate = 0; req = "R6"; end
      else if (md && !mh && !mm && !ms) begin rate = 1; req = "R7"; end
      else if (md && mh && !mm && !ms) begin rate = 2; req = "R8"; end
      else if (md && mh && mm && !ms) begin rate = 3; req = "R9"; end
      else begin rate = 4; req = "R10"; end
      for (int vr = 0; vr < 5; vr++) begin
        bit se, me, he, de, exp;
        se = (vr != 1); me = (vr != 2); he = (vr != 3); de = (vr != 4);
        case (rate)
          0: exp = se && me && he && de;
          1: exp = se && me && he;
          2: exp = se && me;
          3: exp = se;
          default: exp = 1'b1;
        endcase
        fire(req, se ? 7'h12 : 7'h13, me ? 7'h34 : 7'h35,
             he ? 6'h05 : 6'h06, de ? 6'h17 : 6'h18, exp);
      end
    end
    // R11 gating: masks now all set (every second)
    wr(3'd4, 8'h00);
    fire("R11", 7'h00, 7'h00, 6'h00, 6'h01, 1'b0);
    wr(3'd4, 8'h7F);
    fire("R11", 7'h00, 7'h00, 6'h00, 6'h01, 1'b0);
    wr(3'd4, 8'h80);
    tick = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R11", {7'b0, irq_out}, 8'h00);
    end
    fire("R11", 7'h00, 7'h00, 6'h00, 6'h01, 1'b1);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule